// File: doc/BRIEF.md
# Burst Host-to-Byte-Bus Bridge

This bridge joins a synchronous host bus to a narrow internal system bus that moves one byte plus one parity bit per transfer. The host side is set to a lane width of one, two or four bytes. Each host command is either a single beat of that width or a burst that always moves sixteen bytes, as 16, 8 or 4 beats. A command carries the starting internal address. Each byte on the internal bus advances that address by one.

Two byte-wide elastic FIFOs, one per direction, sit between the sides. The host can push or pull beats at its own pace while the internal side moves bytes whenever the bus is granted. Write beats are split into bytes, highest lane first. Read bytes are packed back into host beats in the same order. Even parity is generated on every outgoing byte and on every host read lane. Parity is checked on every incoming internal byte, and optionally on host write lanes. A mismatch raises a sticky error flag.

Top module: `bib_bridge`

## Requirements
- R1: `cfg_width` selects the host lane count when a command is accepted: 0 gives one byte (bits 7:0), 1 gives two bytes (bits 15:0), and 2 or 3 gives four bytes (bits 31:0). Unused upper read lanes return zero.
- R2: A command with `h_cmd_burst`=1 moves exactly 16 bytes, which is 16, 8 or 4 host beats. With `h_cmd_burst`=0 it moves exactly one host beat.
- R3: Inside a beat, the byte in the highest used lane goes on the internal bus first. Read bytes fill the highest used lane first. `ib_addr` starts at `h_cmd_addr` and rises by one after every internal transfer.
- R4: Each direction buffers 16 bytes. `h_wready` is high only while a write command has beats left and the write FIFO has room for a whole beat. `h_rvalid` is high only while a read command has beats left and a whole beat is buffered.
- R5: `ib_wpar` is the XOR of `ib_wdata` (even parity). Each bit of `h_rpar` is the XOR of its lane of `h_rdata`.
- R6: `par_err` is set the cycle after an internal read byte whose `ib_rpar` is not the XOR of `ib_rdata`. It is also set after an accepted host write beat with a used lane whose `h_wpar` bit mismatches, while `cfg_par_en` is 1. `err_clr` clears it, and a new error in the same cycle wins.
- R7: `ib_req` is high while bytes of the current command remain. It drops in the cycle after the last byte. `ib_stb` marks a transfer and needs `ib_req` and `ib_gnt`, plus a buffered byte (write) or free room (read).
- R8: `h_cmd_rdy` is high only while no command is in progress. A write ends after its last internal byte, and a read ends after its last host beat.
- R9: After reset, `h_cmd_rdy`=1, and `ib_req`, `h_wready`, `h_rvalid` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_width | input | 2 | Host lane width code |
| cfg_par_en | input | 1 | Enable host write parity check |
| h_cmd_valid | input | 1 | Command offered |
| h_cmd_wr | input | 1 | 1 = write, 0 = read |
| h_cmd_burst | input | 1 | 1 = 16-byte burst, 0 = single beat |
| h_cmd_addr | input | 8 | Starting internal address |
| h_cmd_rdy | output | 1 | Bridge idle, command accepted |
| h_wvalid | input | 1 | Write beat offered |
| h_wdata | input | 32 | Write beat, right aligned |
| h_wpar | input | 4 | Write lane parity |
| h_wready | output | 1 | Write beat accepted |
| h_rvalid | output | 1 | Read beat available |
| h_rready | input | 1 | Host takes read beat |
| h_rdata | output | 32 | Read beat, right aligned |
| h_rpar | output | 4 | Read lane parity |
| ib_req | output | 1 | Internal bus request |
| ib_gnt | input | 1 | Internal bus grant |
| ib_stb | output | 1 | Byte transfer this cycle |
| ib_wr | output | 1 | Transfer direction |
| ib_addr | output | 8 | Byte address |
| ib_wdata | output | 8 | Write byte |
| ib_wpar | output | 1 | Write byte parity |
| ib_rdata | input | 8 | Read byte, sampled on `ib_stb` |
| ib_rpar | input | 1 | Read byte parity |
| err_clr | input | 1 | Clear parity error |
| par_err | output | 1 | Sticky parity error |

## Verification
Every output is decoded from registered state and the current inputs. A write beat taken at an edge can therefore appear as `ib_stb` right after that edge. A read byte taken at an edge can complete an `h_rvalid` beat in the very next cycle. `par_err` follows a bad byte one edge later, and `ib_req` falls one edge after the last strobe. The bench model applies each effect at the same edge and compares all outputs at the falling edge of every cycle, so each result is checked in the cycle it is due and never later.

// File: rtl/bib_pkg.sv
package bib_pkg;
    typedef enum logic {S_IDLE, S_BUSY} seq_state_e;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

    // lane count selected by the width code
    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bib_fifo.sv
module bib_fifo #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NW-1:0]      push_n,
    input  logic [LANES*8-1:0] push_data,
    input  logic [NW-1:0]      pop_n,
    output logic [LANES*8-1:0] head,
    output logic [CW-1:0]      count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t q, d;

    always_comb begin
        d = q;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_n))
                d.mem[PW'(q.wr + PW'(k))] = push_data[k*8 +: 8];
        end
        d.wr  = q.wr + PW'(push_n);
        d.rd  = q.rd + PW'(pop_n);
        d.cnt = q.cnt + CW'(push_n) - CW'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            head[k*8 +: 8] = q.mem[PW'(q.rd + PW'(k))];
    end

    assign count = q.cnt;
endmodule

// File: rtl/bib_seq.sv
module bib_seq
    import bib_pkg::*;
#(
    parameter int AW    = 8,
    parameter int BURST = 16,
    localparam int BW = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic          start_burst,
    input  logic [AW-1:0] start_addr,
    input  logic [2:0]    start_nb,
    input  logic          host_beat,
    input  logic          ib_xfer,
    output logic          busy,
    output logic          wr,
    output logic [2:0]    nb,
    output logic [BW-1:0] beats,
    output logic [BW-1:0] bytes,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        seq_state_e    st;
        logic          wr;
        logic [2:0]    nb;
        logic [BW-1:0] beats;
        logic [BW-1:0] bytes;
        logic [AW-1:0] addr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_BUSY;
                    d.wr   = start_wr;
                    d.nb   = start_nb;
                    d.addr = start_addr;
                    if (start_burst) begin
                        d.bytes = BW'(BURST);
                        d.beats = (start_nb == 3'd4) ? BW'(BURST / 4) :
                                  (start_nb == 3'd2) ? BW'(BURST / 2) : BW'(BURST);
                    end else begin
                        d.bytes = BW'(start_nb);
                        d.beats = BW'(1);
                    end
                end
            end
            S_BUSY: begin
                if (host_beat) d.beats = q.beats - BW'(1);
                if (ib_xfer) begin
                    d.bytes = q.bytes - BW'(1);
                    d.addr  = q.addr + AW'(1);
                end
                if (q.wr ? (d.bytes == '0) : (d.beats == '0)) d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign busy  = (q.st == S_BUSY);
    assign wr    = q.wr;
    assign nb    = q.nb;
    assign beats = q.beats;
    assign bytes = q.bytes;
    assign addr  = q.addr;
endmodule

// File: rtl/bib_bridge.sv
module bib_bridge
    import bib_pkg::*;
#(
    parameter int AW    = 8,
    parameter int HW    = 32,
    parameter int DEPTH = 16,
    parameter int BURST = 16,
    localparam int HB = HW / 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(HB + 1),
    localparam int BW = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_par_en,
    input  logic          h_cmd_valid,
    input  logic          h_cmd_wr,
    input  logic          h_cmd_burst,
    input  logic [AW-1:0] h_cmd_addr,
    output logic          h_cmd_rdy,
    input  logic          h_wvalid,
    input  logic [HW-1:0] h_wdata,
    input  logic [HB-1:0] h_wpar,
    output logic          h_wready,
    output logic          h_rvalid,
    input  logic          h_rready,
    output logic [HW-1:0] h_rdata,
    output logic [HB-1:0] h_rpar,
    output logic          ib_req,
    input  logic          ib_gnt,
    output logic          ib_stb,
    output logic          ib_wr,
    output logic [AW-1:0] ib_addr,
    output logic [7:0]    ib_wdata,
    output logic          ib_wpar,
    input  logic [7:0]    ib_rdata,
    input  logic          ib_rpar,
    input  logic          err_clr,
    output logic          par_err
);
    typedef struct packed {
        logic err;
    } err_t;

    logic          busy, wr;
    logic [2:0]    nb;
    logic [BW-1:0] beats, bytes;
    logic [AW-1:0] addr;
    logic [CW-1:0] wcnt, rcnt;
    logic [HW-1:0] whead, rhead, wpush_data;
    logic          start, h_wacc, h_racc, hw_bad, rd_bad;
    logic [NW-1:0] wpush_n, wpop_n, rpush_n, rpop_n;
    err_t          err_q, err_d;

    assign start    = !busy && h_cmd_valid;
    assign h_wready = busy && wr && (beats != '0) && ((CW'(DEPTH) - wcnt) >= CW'(nb));
    assign h_rvalid = busy && !wr && (beats != '0) && (rcnt >= CW'(nb));
    assign h_wacc   = h_wready && h_wvalid;
    assign h_racc   = h_rvalid && h_rready;
    assign ib_req   = busy && (bytes != '0);
    assign ib_stb   = ib_req && ib_gnt && (wr ? (wcnt != '0) : (rcnt != CW'(DEPTH)));

    assign wpush_n = h_wacc ? NW'(nb) : '0;
    assign wpop_n  = NW'(ib_stb && wr);
    assign rpush_n = NW'(ib_stb && !wr);
    assign rpop_n  = h_racc ? NW'(nb) : '0;

    bib_seq #(.AW(AW), .BURST(BURST)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_wr(h_cmd_wr), .start_burst(h_cmd_burst),
        .start_addr(h_cmd_addr), .start_nb(lanes_of(cfg_width)),
        .host_beat(h_wacc || h_racc), .ib_xfer(ib_stb),
        .busy(busy), .wr(wr), .nb(nb), .beats(beats), .bytes(bytes), .addr(addr)
    );

    bib_fifo #(.DEPTH(DEPTH), .LANES(HB)) u_wfifo (
        .clk(clk), .rst_n(rst_n),
        .push_n(wpush_n), .push_data(wpush_data), .pop_n(wpop_n),
        .head(whead), .count(wcnt)
    );

    bib_fifo #(.DEPTH(DEPTH), .LANES(HB)) u_rfifo (
        .clk(clk), .rst_n(rst_n),
        .push_n(rpush_n), .push_data({{(HW-8){1'b0}}, ib_rdata}), .pop_n(rpop_n),
        .head(rhead), .count(rcnt)
    );

    // lane reordering: highest used lane travels first
    always_comb begin
        wpush_data = '0;
        hw_bad     = 1'b0;
        h_rdata    = '0;
        for (int k = 0; k < HB; k++) begin
            if (k < int'(nb)) begin
                wpush_data[k*8 +: 8] = h_wdata[(int'(nb) - 1 - k)*8 +: 8];
                if (h_wpar[k] != even_par(h_wdata[k*8 +: 8])) hw_bad = 1'b1;
                h_rdata[k*8 +: 8] = rhead[(int'(nb) - 1 - k)*8 +: 8];
            end
        end
        for (int j = 0; j < HB; j++)
            h_rpar[j] = even_par(h_rdata[j*8 +: 8]);
    end

    assign rd_bad = ib_stb && !wr && (ib_rpar != even_par(ib_rdata));

    always_comb begin
        err_d = err_q;
        if (err_clr) err_d.err = 1'b0;
        if (rd_bad || (h_wacc && cfg_par_en && hw_bad)) err_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign h_cmd_rdy = !busy;
    assign ib_wr     = wr;
    assign ib_addr   = addr;
    assign ib_wdata  = whead[7:0];
    assign ib_wpar   = even_par(whead[7:0]);
    assign par_err   = err_q.err;
endmodule

// File: rtl/bib_bridge_chk.sv
module bib_bridge_chk #(
    parameter int AW    = 8,
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ib_stb,
    input logic          ib_req,
    input logic          ib_gnt,
    input logic          ib_wr,
    input logic [AW-1:0] ib_addr,
    input logic [7:0]    ib_rdata,
    input logic          ib_rpar,
    input logic          h_wready,
    input logic          h_rvalid,
    input logic          h_cmd_rdy,
    input logic          par_err,
    input logic          err_clr,
    input logic [CW-1:0] wcnt,
    input logic [CW-1:0] rcnt
);
    assert_stb_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ib_stb |-> (ib_req && ib_gnt));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt <= CW'(DEPTH)) && (rcnt <= CW'(DEPTH)));

    assert_host_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wready || h_rvalid) |-> !h_cmd_rdy);

    assert_bad_read_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_stb && !ib_wr && (ib_rpar != ^ib_rdata)) |=> par_err);

    assert_err_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_err) |-> $past(err_clr));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ib_stb |=> (ib_addr == $past(ib_addr) + AW'(1)));
endmodule

bind bib_bridge bib_bridge_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ib_stb(ib_stb), .ib_req(ib_req), .ib_gnt(ib_gnt),
    .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_rdata(ib_rdata), .ib_rpar(ib_rpar),
    .h_wready(h_wready), .h_rvalid(h_rvalid), .h_cmd_rdy(h_cmd_rdy),
    .par_err(par_err), .err_clr(err_clr), .wcnt(wcnt), .rcnt(rcnt)
);

// File: tb/tb_bib_bridge.sv
module tb_bib_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_width;
    logic        cfg_par_en;
    logic        h_cmd_valid, h_cmd_wr, h_cmd_burst;
    logic [7:0]  h_cmd_addr;
    logic        h_cmd_rdy;
    logic        h_wvalid;
    logic [31:0] h_wdata;
    logic [3:0]  h_wpar;
    logic        h_wready, h_rvalid, h_rready;
    logic [31:0] h_rdata;
    logic [3:0]  h_rpar;
    logic        ib_req, ib_gnt, ib_stb, ib_wr, ib_wpar, ib_rpar;
    logic [7:0]  ib_addr, ib_wdata, ib_rdata, salt;
    logic        err_clr, par_err, inj_rpar;

    int checks = 0, errors = 0;
    int gnt_p = 70, wv_p = 70, rr_p = 70;
    bit wpar_bad_mode = 0, rpar_bad_mode = 0, finished = 0;

    always #4 clk = ~clk;

    bib_bridge dut (.*);

    assign ib_rdata = ib_addr ^ 8'hA5 ^ salt;
    assign ib_rpar  = (^ib_rdata) ^ inj_rpar;

    // reference model state
    bit         m_busy, m_wr, m_err;
    int         m_nb, m_beats, m_bytes;
    logic [7:0] m_addr;
    logic [7:0] wq[$];
    logic [7:0] rq[$];
    bit         e_wready, e_rvalid, e_req, e_stb;
    logic [31:0] e_rdata;
    logic [3:0]  e_rpar;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic calc();
        e_wready = m_busy && m_wr && m_beats > 0 && (16 - wq.size()) >= m_nb;
        e_rvalid = m_busy && !m_wr && m_beats > 0 && rq.size() >= m_nb;
        e_req    = m_busy && m_bytes > 0;
        e_stb    = e_req && ib_gnt && (m_wr ? wq.size() > 0 : rq.size() < 16);
        e_rdata  = '0;
        e_rpar   = '0;
        if (e_rvalid)
            for (int j = 0; j < m_nb; j++) e_rdata[j*8 +: 8] = rq[m_nb - 1 - j];
        for (int j = 0; j < 4; j++) e_rpar[j] = ^e_rdata[j*8 +: 8];
    endtask

    always @(posedge clk) begin
        bit set;
        if (!rst_n) begin
            m_busy = 0; m_wr = 0; m_err = 0; m_nb = 1; m_beats = 0; m_bytes = 0;
            m_addr = 0; wq.delete(); rq.delete();
        end else begin
            calc();
            set = 0;
            if (!m_busy) begin
                if (h_cmd_valid) begin
                    m_busy  = 1;
                    m_wr    = h_cmd_wr;
                    m_nb    = (cfg_width == 0) ? 1 : (cfg_width == 1) ? 2 : 4;
                    m_addr  = h_cmd_addr;
                    m_beats = h_cmd_burst ? 16 / m_nb : 1;
                    m_bytes = m_beats * m_nb;
                end
            end else begin
                if (e_stb) begin
                    if (m_wr) void'(wq.pop_front());
                    else begin
                        rq.push_back(ib_rdata);
                        if (ib_rpar != ^ib_rdata) set = 1;
                    end
                    m_addr++;
                    m_bytes--;
                end
                if (e_wready && h_wvalid) begin
                    for (int k = 0; k < m_nb; k++) begin
                        wq.push_back(h_wdata[(m_nb - 1 - k)*8 +: 8]);
                        if (cfg_par_en && h_wpar[k] != ^h_wdata[k*8 +: 8]) set = 1;
                    end
                    m_beats--;
                end
                if (e_rvalid && h_rready) begin
                    for (int k = 0; k < m_nb; k++) void'(rq.pop_front());
                    m_beats--;
                end
                if (m_wr ? m_bytes == 0 : m_beats == 0) m_busy = 0;
            end
            if (err_clr) m_err = 0;
            if (set) m_err = 1;
        end
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            calc();
            chk("R8 h_cmd_rdy", 32'(h_cmd_rdy), 32'(!m_busy));
            chk("R4 h_wready", 32'(h_wready), 32'(e_wready));
            chk("R4 h_rvalid", 32'(h_rvalid), 32'(e_rvalid));
            chk("R7 ib_req", 32'(ib_req), 32'(e_req));
            chk("R7 ib_stb", 32'(ib_stb), 32'(e_stb));
            chk("R6 par_err", 32'(par_err), 32'(m_err));
            if (e_req) begin
                chk("R3 ib_addr", 32'(ib_addr), 32'(m_addr));
                chk("R2 ib_wr", 32'(ib_wr), 32'(m_wr));
            end
            if (e_stb && m_wr) begin
                chk("R3 ib_wdata", 32'(ib_wdata), 32'(wq[0]));
                chk("R5 ib_wpar", 32'(ib_wpar), 32'(^wq[0]));
            end
            if (e_rvalid) begin
                chk("R1 h_rdata", h_rdata, e_rdata);
                chk("R5 h_rpar", 32'(h_rpar), 32'(e_rpar));
            end
        end
    end

    // random handshakes and data
    always @(posedge clk) begin
        #2;
        ib_gnt   = $urandom_range(0, 99) < gnt_p;
        h_wvalid = $urandom_range(0, 99) < wv_p;
        h_rready = $urandom_range(0, 99) < rr_p;
        h_wdata  = $urandom;
        for (int j = 0; j < 4; j++) h_wpar[j] = ^h_wdata[j*8 +: 8];
        if (wpar_bad_mode && $urandom_range(0, 3) == 0) h_wpar[0] = ~h_wpar[0];
        inj_rpar = rpar_bad_mode && $urandom_range(0, 7) == 0;
        salt     = 8'($urandom);
    end

    task automatic run_cmd(input logic [1:0] w, input bit wr, input bit burst, input logic [7:0] a);
        int n;
        @(posedge clk); #2;
        cfg_width = w; h_cmd_wr = wr; h_cmd_burst = burst; h_cmd_addr = a; h_cmd_valid = 1;
        @(posedge clk); #2;
        h_cmd_valid = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!h_cmd_rdy && n < 3000);
        chk("R8 command completes", 32'(h_cmd_rdy), 32'd1);
    endtask

    initial begin
        rst_n = 0; cfg_width = 0; cfg_par_en = 0; h_cmd_valid = 0; h_cmd_wr = 0;
        h_cmd_burst = 0; h_cmd_addr = 0; err_clr = 0;
        ib_gnt = 0; h_wvalid = 0; h_rready = 0; h_wdata = 0; h_wpar = 0; inj_rpar = 0; salt = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R9 reset h_cmd_rdy", 32'(h_cmd_rdy), 32'd1);
        chk("R9 reset ib_req", 32'(ib_req), 32'd0);
        chk("R9 reset h_wready", 32'(h_wready), 32'd0);
        chk("R9 reset h_rvalid", 32'(h_rvalid), 32'd0);
        chk("R9 reset par_err", 32'(par_err), 32'd0);

        // R1 R2: every width, both directions, single and burst
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 2; b++) begin
                run_cmd(2'(w), 1'b1, b[0], 8'(16 * w + 8 * b));
                run_cmd(2'(w), 1'b0, b[0], 8'(16 * w + 8 * b + 3));
            end

        // R4: slow host drains, fast bus fills the read FIFO; then slow bus
        gnt_p = 100; rr_p = 10; wv_p = 100;
        run_cmd(2'd0, 1'b0, 1'b1, 8'hF8);
        run_cmd(2'd2, 1'b1, 1'b1, 8'h40);
        gnt_p = 5;
        run_cmd(2'd1, 1'b1, 1'b1, 8'h80);
        gnt_p = 70; rr_p = 70; wv_p = 70;

        // R6: host write parity ignored while disabled, flagged while enabled
        wpar_bad_mode = 1;
        run_cmd(2'd2, 1'b1, 1'b1, 8'h10);
        chk("R6 host parity off keeps flag low", 32'(par_err), 32'd0);
        cfg_par_en = 1;
        wv_p = 100;
        run_cmd(2'd2, 1'b1, 1'b1, 8'h20);
        chk("R6 host parity flag", 32'(par_err), 32'd1);
        wpar_bad_mode = 0; cfg_par_en = 0; wv_p = 70;
        @(posedge clk); #2 err_clr = 1;
        @(posedge clk); #2 err_clr = 0;
        @(negedge clk);
        chk("R6 clear", 32'(par_err), 32'd0);

        // R6: corrupted internal read bytes
        rpar_bad_mode = 1;
        run_cmd(2'd0, 1'b0, 1'b1, 8'h30);
        rpar_bad_mode = 0;
        chk("R6 read parity flag", 32'(par_err), 32'd1);
        @(posedge clk); #2 err_clr = 1;
        @(posedge clk); #2 err_clr = 0;
        run_cmd(2'd1, 1'b0, 1'b0, 8'h55);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R8 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule